// File: doc/BRIEF.md
# Serial Bit-Rate Tick Selector

This block turns the timing sources around a serial port into the ticks that the port's shift logic consumes. Two timer overflow pulse streams arrive as inputs. The block also derives fixed rates from its own clock. From these it produces three outputs: a 16x-oversample tick for the receiver, a 16x-oversample tick for the transmitter, and a bit clock for the synchronous shift-register mode. The serial engine and the timers sit outside it.

A two-bit mode code chooses the rate family. The shift mode uses a fixed divide of the clock, giving a bit rate of clock/12. The fixed nine-bit mode uses clock/64 or clock/32, picked by the rate-doubling input. The two variable modes take their rate from the timers. In the variable modes, receive and transmit each pick timer 1 or timer 2 on their own, so the two directions can run at different rates at the same time. Rate doubling acts only on the timer-1 path. Without doubling, timer 1 is divided by 32 to form the bit rate. With doubling, and always for timer 2, the divide is 16.

Top module: `sbt_baud_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all three tick outputs are 0. Reset also restarts the fixed dividers and the timer-1 prescalers.
- R2: Mode codes are 2'b00 shift, 2'b01 variable 8-bit, 2'b10 fixed 9-bit and 2'b11 variable 9-bit. In mode 2'b00, `shift_tick_o` is high for one cycle after every 12th rising edge counted from reset release, and both `rx_tick_o` and `tx_tick_o` stay 0.
- R3: In mode 2'b10, with `dbl_i` = 0, both 16x ticks pulse after every 4th edge counted from reset release (bit rate clock/64). With `dbl_i` = 1 they pulse after every 2nd edge (bit rate clock/32). The select inputs have no effect in this mode.
- R4: In modes 2'b01 and 2'b11, a direction whose select is 0 (timer 1) with `dbl_i` = 0 ticks on every second timer-1 pulse. Pulses are counted from reset regardless of mode or select, and the tick appears on the 2nd, 4th and later pulses.
- R5: In modes 2'b01 and 2'b11, a direction on timer 1 with `dbl_i` = 1 ticks once for every timer-1 pulse.
- R6: In modes 2'b01 and 2'b11, a direction whose select is 1 (timer 2) ticks once for every timer-2 pulse, whatever `dbl_i` is.
- R7: `rx_use_t2_i` steers only `rx_tick_o` and `tx_use_t2_i` steers only `tx_tick_o`, so the two directions can use different timers at the same time.
- R8: `shift_tick_o` is 0 in every mode other than 2'b00.
- R9: Every tick is registered and appears one cycle after the edge at which its source pulse and configuration were sampled. In modes 2'b01 and 2'b11 no tick is raised without a source pulse. A change of select takes effect at the next source pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Serial mode code |
| t1_ovf_i | input | 1 | Timer 1 overflow pulse |
| t2_ovf_i | input | 1 | Timer 2 overflow pulse |
| rx_use_t2_i | input | 1 | Receive source: 1 timer 2, 0 timer 1 |
| tx_use_t2_i | input | 1 | Transmit source: 1 timer 2, 0 timer 1 |
| dbl_i | input | 1 | Rate doubling (timer 1 paths and mode 2) |
| rx_tick_o | output | 1 | Receiver 16x-oversample tick |
| tx_tick_o | output | 1 | Transmitter 16x-oversample tick |
| shift_tick_o | output | 1 | Shift-mode bit clock |

## Verification
A timer-1 prescaler that slips by one pulse moves every later undoubled tick by one source pulse. The bench sees this at the next timer-1 pulse, because its per-cycle model counts pulses independently. A fixed divider with a wrong terminal count shifts the shift-mode or mode-2 tick within one divider period, which is at most 12 cycles. A wrong mux leg shows up as a tick in the wrong direction, or in the wrong mode, in the cycle after the first source pulse that reaches it.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    SER_SHIFT = 2'b00,
    SER_VAR8  = 2'b01,
    SER_FIX9  = 2'b10,
    SER_VAR9  = 2'b11
  } ser_mode_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_RX  = 0;
  localparam int unsigned DIR_TX  = 1;

  function automatic logic is_timer_mode(input ser_mode_e m);
    return (m == SER_VAR8) || (m == SER_VAR9);
  endfunction
endpackage

// File: rtl/sbt_div.sv
module sbt_div #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic pulse_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = (cnt_q == LAST);
endmodule

// File: rtl/sbt_chan.sv
module sbt_chan
  import sbt_pkg::*;
#(
  parameter int unsigned T1_SLOW_DIV = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  ser_mode_e mode_i,
  input  logic      t1_ovf_i,
  input  logic      t2_ovf_i,
  input  logic      use_t2_i,
  input  logic      dbl_i,
  input  logic      fix_slow_i,
  input  logic      fix_fast_i,
  output logic      tick_o
);
  localparam int unsigned PW = (T1_SLOW_DIV > 1) ? $clog2(T1_SLOW_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(T1_SLOW_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          t1_slow;
  logic          tick_d;
  logic          tick_q;

  // prescaler advances on every timer-1 pulse, independent of selection
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (t1_ovf_i) begin
      pre_q <= (pre_q == PLAST) ? '0 : pre_q + 1'b1;
    end
  end

  assign t1_slow = t1_ovf_i && (pre_q == PLAST);

  always_comb begin
    unique case (mode_i)
      SER_SHIFT: tick_d = 1'b0;
      SER_FIX9:  tick_d = dbl_i ? fix_fast_i : fix_slow_i;
      default: begin
        if (use_t2_i) begin
          tick_d = t2_ovf_i;
        end else begin
          tick_d = dbl_i ? t1_ovf_i : t1_slow;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/sbt_baud_sel.sv
module sbt_baud_sel
  import sbt_pkg::*;
#(
  parameter int unsigned SHIFT_DIV   = 12,
  parameter int unsigned FIX_SLOW    = 4,
  parameter int unsigned FIX_FAST    = 2,
  parameter int unsigned T1_SLOW_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       t1_ovf_i,
  input  logic       t2_ovf_i,
  input  logic       rx_use_t2_i,
  input  logic       tx_use_t2_i,
  input  logic       dbl_i,
  output logic       rx_tick_o,
  output logic       tx_tick_o,
  output logic       shift_tick_o
);
  ser_mode_e            mode;
  logic                 shift_pulse;
  logic                 fix_slow;
  logic                 fix_fast;
  logic [NUM_DIR-1:0]   use_t2;
  logic [NUM_DIR-1:0]   ticks;
  logic                 shift_q;

  assign mode   = ser_mode_e'(mode_i);
  assign use_t2 = {tx_use_t2_i, rx_use_t2_i};

  sbt_div #(.DIV(SHIFT_DIV)) u_div_shift (.clk(clk), .rst(rst), .pulse_o(shift_pulse));
  sbt_div #(.DIV(FIX_SLOW))  u_div_slow  (.clk(clk), .rst(rst), .pulse_o(fix_slow));
  sbt_div #(.DIV(FIX_FAST))  u_div_fast  (.clk(clk), .rst(rst), .pulse_o(fix_fast));

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    sbt_chan #(.T1_SLOW_DIV(T1_SLOW_DIV)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .mode_i    (mode),
      .t1_ovf_i  (t1_ovf_i),
      .t2_ovf_i  (t2_ovf_i),
      .use_t2_i  (use_t2[g]),
      .dbl_i     (dbl_i),
      .fix_slow_i(fix_slow),
      .fix_fast_i(fix_fast),
      .tick_o    (ticks[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= 1'b0;
    end else begin
      shift_q <= (mode == SER_SHIFT) && shift_pulse;
    end
  end

  assign rx_tick_o    = ticks[DIR_RX];
  assign tx_tick_o    = ticks[DIR_TX];
  assign shift_tick_o = shift_q;
endmodule

// File: rtl/sbt_baud_sel_chk.sv
module sbt_baud_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       t1_ovf_i,
  input logic       t2_ovf_i,
  input logic       rx_use_t2_i,
  input logic       dbl_i,
  input logic       rx_tick_o,
  input logic       tx_tick_o,
  input logic       shift_tick_o
);
  // R2: no oversample ticks in shift mode
  a_r2_quiet_in_shift: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> (!rx_tick_o && !tx_tick_o));

  // R2: bit clock pulses are isolated
  a_r2_shift_isolated: assert property (@(posedge clk) disable iff (rst)
    shift_tick_o |=> !shift_tick_o);

  // R8: no bit clock outside shift mode
  a_r8_shift_only_mode0: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b00) |=> !shift_tick_o);

  // R6: receive on timer 2 follows the timer-2 pulse one cycle later
  a_r6_rx_follows_t2: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode_i[0] && rx_use_t2_i) |=> (rx_tick_o == $past(t2_ovf_i)));

  // R9: no source pulse, no tick in timer modes
  a_r9_no_source_no_tick: assert property (@(posedge clk) disable iff (rst)
    (mode_i[0] && !t1_ovf_i && !t2_ovf_i) |=> (!rx_tick_o && !tx_tick_o));

  // R3: slow fixed rate never gives back-to-back ticks
  a_r3_slow_gap: assert property (@(posedge clk) disable iff (rst)
    (rx_tick_o && mode_i == 2'b10 && !dbl_i) |=> !rx_tick_o);
endmodule

bind sbt_baud_sel sbt_baud_sel_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .t1_ovf_i    (t1_ovf_i),
  .t2_ovf_i    (t2_ovf_i),
  .rx_use_t2_i (rx_use_t2_i),
  .dbl_i       (dbl_i),
  .rx_tick_o   (rx_tick_o),
  .tx_tick_o   (tx_tick_o),
  .shift_tick_o(shift_tick_o)
);

// File: tb/sbt_baud_sel_tb_top.sv
`timescale 1ns/1ps
module sbt_baud_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       t1 = 1'b0, t2 = 1'b0, rx_t2 = 1'b0, tx_t2 = 1'b0, dbl = 1'b0;
  logic       rx_tick, tx_tick, shift_tick;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_en  = 1'b0;

  always #2 clk = ~clk;

  sbt_baud_sel dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .t1_ovf_i(t1), .t2_ovf_i(t2),
    .rx_use_t2_i(rx_t2), .tx_use_t2_i(tx_t2), .dbl_i(dbl),
    .rx_tick_o(rx_tick), .tx_tick_o(tx_tick), .shift_tick_o(shift_tick)
  );

  // reference model built from the requirements
  int    m_c12 = 0, m_c4 = 0, m_c2 = 0, m_t1n = 0;
  logic  e_rx = 0, e_tx = 0, e_sh = 0;
  string tag_rx = "R1", tag_tx = "R1", tag_sh = "R1";

  function automatic logic exp_dir(input logic [1:0] md, input logic sel2,
                                   input int c4, input int c2, input int t1n);
    case (md)
      2'b00: return 1'b0;
      2'b10: return dbl ? (c2 == 1) : (c4 == 3);
      default: begin
        if (sel2) return t2;
        if (dbl)  return t1;
        return t1 && ((t1n % 2) == 1);
      end
    endcase
  endfunction

  function automatic string dir_tag(input logic [1:0] md, input logic sel2);
    if (md == 2'b00) return "R2";
    if (md == 2'b10) return "R3";
    if (sel2)        return "R6";
    return dbl ? "R5" : "R4";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_c12 <= 0; m_c4 <= 0; m_c2 <= 0; m_t1n <= 0;
      e_rx <= 0; e_tx <= 0; e_sh <= 0;
      tag_rx <= "R1"; tag_tx <= "R1"; tag_sh <= "R1";
    end else begin
      e_rx   <= exp_dir(mode, rx_t2, m_c4, m_c2, m_t1n);
      e_tx   <= exp_dir(mode, tx_t2, m_c4, m_c2, m_t1n);
      e_sh   <= (mode == 2'b00) && (m_c12 == 11);
      tag_rx <= dir_tag(mode, rx_t2);
      tag_tx <= (rx_t2 != tx_t2) ? "R7" : dir_tag(mode, tx_t2);
      tag_sh <= (mode == 2'b00) ? "R2" : "R8";
      m_c12  <= (m_c12 + 1) % 12;
      m_c4   <= (m_c4 + 1) % 4;
      m_c2   <= (m_c2 + 1) % 2;
      if (t1) m_t1n <= m_t1n + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp_v, input string what);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(tag_rx, rx_tick, e_rx, "rx_tick");
      check(tag_tx, tx_tick, e_tx, "tx_tick");
      check(tag_sh, shift_tick, e_sh, "shift_tick");
    end
  end

  int cnt_rx = 0, cnt_tx = 0, cnt_sh = 0;
  always @(negedge clk) begin
    cnt_rx += int'(rx_tick);
    cnt_tx += int'(tx_tick);
    cnt_sh += int'(shift_tick);
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    chk_en = 1'b0;
    rst = 1'b1; t1 = 0; t2 = 0;
    repeat (3) @(negedge clk);
    check("R1", rx_tick | tx_tick | shift_tick, 1'b0, "outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", rx_tick | tx_tick | shift_tick, 1'b0, "outputs after reset");
    chk_en = 1'b1;
  endtask

  task automatic step(input logic p1, input logic p2);
    t1 = p1; t2 = p2;
    @(negedge clk);
  endtask

  task automatic clear_counts();
    cnt_rx = 0; cnt_tx = 0; cnt_sh = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (2) @(negedge clk);

    // shift mode (R2)
    mode = 2'b00; dbl = 0; rx_t2 = 0; tx_t2 = 0;
    do_reset();
    clear_counts();
    repeat (48) step(1'b1, 1'b1);
    step(0, 0);
    check("R2", cnt_sh == 4, 1'b1, "shift ticks in 48 cycles");
    check("R2", (cnt_rx + cnt_tx) == 0, 1'b1, "no 16x ticks in mode 0");

    // fixed 9-bit mode, slow then fast (R3)
    mode = 2'b10; dbl = 0; rx_t2 = 1; tx_t2 = 0;
    do_reset();
    clear_counts();
    repeat (64) step(1'b1, 1'b1);
    check("R3", cnt_rx == 16 && cnt_tx == 16, 1'b1, "slow rate ticks in 64 cycles");
    check("R8", cnt_sh == 0, 1'b1, "no shift ticks in mode 2");
    dbl = 1;
    step(0, 0);
    clear_counts();
    repeat (64) step(1'b0, 1'b0);
    check("R3", cnt_rx == 32, 1'b1, "fast rate ticks in 64 cycles");

    // timer modes: rx on timer 2, tx on timer 1 undoubled (R4, R6, R7)
    mode = 2'b01; dbl = 0; rx_t2 = 1; tx_t2 = 0;
    do_reset();
    clear_counts();
    for (int i = 0; i < 10; i++) begin
      step(1'b1, i < 6);
      step(1'b0, 1'b0);
    end
    step(0, 0);
    check("R4", cnt_tx == 5, 1'b1, "timer1 undoubled halves pulses");
    check("R7", cnt_rx == 6, 1'b1, "rx follows timer2 independently");

    // doubled timer 1 on both (R5), then switch select mid-stream (R9)
    mode = 2'b11; dbl = 1; rx_t2 = 0; tx_t2 = 0;
    clear_counts();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    step(0, 0);
    check("R5", cnt_rx == 8 && cnt_tx == 8, 1'b1, "doubled timer1 every pulse");
    clear_counts();
    rx_t2 = 1;
    repeat (6) step(1'b0, 1'b0);
    check("R9", cnt_rx == 0, 1'b1, "select change with no pulse gives no tick");
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    check("R9", cnt_rx == 1, 1'b1, "new source takes effect on next pulse");

    // random mix, checked cycle by cycle against the model
    for (int blk = 0; blk < 400; blk++) begin
      mode  = 2'($urandom_range(0, 3));
      dbl   = 1'($urandom_range(0, 1));
      rx_t2 = 1'($urandom_range(0, 1));
      tx_t2 = 1'($urandom_range(0, 1));
      if (blk % 97 == 5) do_reset();
      for (int k = 0; k < 40; k++) begin
        step($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
      end
    end

    step(0, 0);
    chk_en = 1'b0;
    finish_run();
  end
endmodule